// File: doc/BRIEF.md
# Rotating-Priority Interrupt Vector Arbiter

This block merges the interrupt requests of several ports, for example two serial channels and a parallel port, onto one shared interrupt line. Each port owns an 8-bit register that the host can write and read back. The same register holds the vector byte that the host receives when it services that port. A single global enable decides whether the merged request reaches the interrupt output.

When the host runs an acknowledge cycle (a one-cycle strobe), the block picks one requesting port and latches that port's vector onto the vector output. It then records the port as the last one served. The port served last drops to the lowest priority. The next search starts at the port after it and wraps round, so a port that requests without pause cannot shut out the others. The per-port interrupt sources are outside the block and arrive as plain request inputs.

Top module: `irq_vector_arbiter`

## Requirements
- R1: Writing with `wr_en_i` high stores `wr_data_i` into the vector register of port `wr_sel_i` at the clock edge. `rd_data_o` shows, combinationally, the register of port `rd_sel_i`.
- R2: After reset every vector register and `vec_o` read 8'h00. The last-served pointer holds the highest-numbered port, so port 0 wins the first acknowledge when all ports request.
- R3: If `iack_i` is high at a clock edge while some port requests, `vec_o` carries the winning port's vector from that edge on. `vec_o` keeps its value at every edge where `iack_i` is low.
- R4: The winner is the first requesting port after the last-served port, in ascending index order, wrapping from the highest index to 0. The winner becomes the new last-served port. Request bit k belongs to port k.
- R5: An acknowledge while no port requests loads 8'h00 into `vec_o` and leaves the last-served pointer unchanged.
- R6: `irq_o` is high exactly when `glb_en_i` is high and at least one request bit is high. It follows the inputs with no register delay.
- R7: When a write and an acknowledge hit the same port in one cycle, the acknowledge returns the value the register held before the write. The write still takes effect.
- R8: A write whose `wr_sel_i` is not below NUM_PORTS changes no vector register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | NUM_PORTS | Interrupt request per port, bit k = port k |
| glb_en_i | input | 1 | Global enable for the interrupt output |
| irq_o | output | 1 | Merged interrupt request |
| iack_i | input | 1 | One-cycle acknowledge strobe |
| vec_o | output | VEC_W | Vector returned by the last acknowledge |
| wr_en_i | input | 1 | Vector register write strobe |
| wr_sel_i | input | SEL_W | Port selected for a write |
| wr_data_i | input | VEC_W | Write data |
| rd_sel_i | input | SEL_W | Port selected for read-back |
| rd_data_o | output | VEC_W | Read-back of the selected vector register |

## Verification
The bench walks a sequence of acknowledges whose expected winners depend on the pointer left by the step before. A design that used fixed priority, or that kept the winner at top priority instead of bottom, returns port 0 or repeats a port where another vector is expected. It acknowledges with no request pending and then checks that the next winner did not move. A design that updated the pointer on an empty acknowledge would pick the wrong port there. It also writes to a port in the same cycle that port is acknowledged, which exposes a vector taken from the new data rather than the held one. Finally it writes to an out-of-range index, which catches a decoder that aliases that index onto a real port.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
   // Width of a port index; never below one bit.
   function automatic int unsigned sel_width(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/irqv_vec_bank.sv
module irqv_vec_bank #(
   parameter int unsigned NUM_PORTS = 3,
   parameter int unsigned VEC_W     = 8,
   parameter int unsigned SEL_W     = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [SEL_W-1:0]           wr_sel,
   input  logic [VEC_W-1:0]           wr_data,
   output logic [NUM_PORTS*VEC_W-1:0] vec_flat
);
   for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
      logic [VEC_W-1:0] slot_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            slot_q <= '0;
         end else if (wr_en && (wr_sel == SEL_W'(g))) begin
            slot_q <= wr_data;
         end
      end
      assign vec_flat[g*VEC_W +: VEC_W] = slot_q;
   end
endmodule

// File: rtl/irqv_rr_pick.sv
module irqv_rr_pick #(
   parameter int unsigned NUM_PORTS = 3,
   parameter int unsigned SEL_W     = 2
) (
   input  logic [NUM_PORTS-1:0] req,
   input  logic [SEL_W-1:0]     last,
   output logic [NUM_PORTS-1:0] grant
);
   // Search from the port after 'last', wrapping; first hit wins.
   always_comb begin
      logic found;
      int   idx;
      grant = '0;
      found = 1'b0;
      for (int k = 1; k <= int'(NUM_PORTS); k++) begin
         idx = (int'(last) + k) % int'(NUM_PORTS);
         if (!found && req[idx]) begin
            grant[idx] = 1'b1;
            found      = 1'b1;
         end
      end
   end
endmodule

// File: rtl/irqv_serve_ptr.sv
module irqv_serve_ptr #(
   parameter int unsigned NUM_PORTS = 3,
   parameter int unsigned SEL_W     = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 advance,
   input  logic [NUM_PORTS-1:0] grant,
   output logic [SEL_W-1:0]     last
);
   logic [SEL_W-1:0] enc;

   always_comb begin
      enc = '0;
      for (int k = 0; k < int'(NUM_PORTS); k++) begin
         if (grant[k]) enc = SEL_W'(k);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last <= SEL_W'(NUM_PORTS - 1);
      end else if (advance && (grant != '0)) begin
         last <= enc;
      end
   end
endmodule

// File: rtl/irq_vector_arbiter.sv
module irq_vector_arbiter #(
   parameter int unsigned NUM_PORTS = 3,
   parameter int unsigned VEC_W     = 8,
   localparam int unsigned SEL_W    = irqv_pkg::sel_width(NUM_PORTS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_PORTS-1:0] req_i,
   input  logic                 glb_en_i,
   output logic                 irq_o,
   input  logic                 iack_i,
   output logic [VEC_W-1:0]     vec_o,
   input  logic                 wr_en_i,
   input  logic [SEL_W-1:0]     wr_sel_i,
   input  logic [VEC_W-1:0]     wr_data_i,
   input  logic [SEL_W-1:0]     rd_sel_i,
   output logic [VEC_W-1:0]     rd_data_o
);
   if (NUM_PORTS < 2) begin : g_bad_ports
      $error("irq_vector_arbiter: NUM_PORTS must be at least 2");
   end
   if (VEC_W < 1) begin : g_bad_width
      $error("irq_vector_arbiter: VEC_W must be at least 1");
   end

   logic [NUM_PORTS*VEC_W-1:0] vec_flat;
   logic [NUM_PORTS-1:0]       grant;
   logic [SEL_W-1:0]           last_srv;
   logic [VEC_W-1:0]           pick_vec;

   irqv_vec_bank #(.NUM_PORTS(NUM_PORTS), .VEC_W(VEC_W), .SEL_W(SEL_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en_i), .wr_sel(wr_sel_i),
      .wr_data(wr_data_i), .vec_flat(vec_flat));

   irqv_rr_pick #(.NUM_PORTS(NUM_PORTS), .SEL_W(SEL_W)) u_pick (
      .req(req_i), .last(last_srv), .grant(grant));

   irqv_serve_ptr #(.NUM_PORTS(NUM_PORTS), .SEL_W(SEL_W)) u_ptr (
      .clk(clk), .rst_n(rst_n), .advance(iack_i), .grant(grant), .last(last_srv));

   // One-hot AND-OR select; zero when nothing is granted.
   always_comb begin
      pick_vec = '0;
      for (int k = 0; k < int'(NUM_PORTS); k++) begin
         pick_vec = pick_vec | ({VEC_W{grant[k]}} & vec_flat[k*VEC_W +: VEC_W]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vec_o <= '0;
      end else if (iack_i) begin
         vec_o <= pick_vec;
      end
   end

   always_comb begin
      rd_data_o = '0;
      for (int k = 0; k < int'(NUM_PORTS); k++) begin
         if (rd_sel_i == SEL_W'(k)) rd_data_o = vec_flat[k*VEC_W +: VEC_W];
      end
   end

   assign irq_o = glb_en_i & (|req_i);
endmodule

// File: rtl/irqv_checker.sv
module irqv_checker #(
   parameter int unsigned NUM_PORTS = 3,
   parameter int unsigned VEC_W     = 8,
   parameter int unsigned SEL_W     = 2
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic [NUM_PORTS-1:0]       req_i,
   input logic                       glb_en_i,
   input logic                       irq_o,
   input logic                       iack_i,
   input logic [VEC_W-1:0]           vec_o,
   input logic                       wr_en_i,
   input logic [SEL_W-1:0]           wr_sel_i,
   input logic [NUM_PORTS*VEC_W-1:0] vec_flat,
   input logic [NUM_PORTS-1:0]       grant
);
   p_irq_on_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (glb_en_i && (req_i != '0)) |-> irq_o);
   p_irq_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !glb_en_i |-> !irq_o);
   p_vec_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !iack_i |=> $stable(vec_o));
   p_idle_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (iack_i && (req_i == '0)) |=> (vec_o == '0));
   p_grant_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));
   p_grant_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (grant & ~req_i) == '0);
   p_grant_some_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i != '0) |-> (grant != '0));
   p_bad_sel_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && (int'(wr_sel_i) >= int'(NUM_PORTS))) |=> $stable(vec_flat));
endmodule

bind irq_vector_arbiter irqv_checker #(
   .NUM_PORTS(NUM_PORTS), .VEC_W(VEC_W), .SEL_W(SEL_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .req_i(req_i), .glb_en_i(glb_en_i), .irq_o(irq_o),
   .iack_i(iack_i), .vec_o(vec_o), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
   .vec_flat(vec_flat), .grant(grant));

// File: tb/irq_vector_arbiter_tb_top.sv
module irq_vector_arbiter_tb_top;
   localparam int N = 3;
   localparam int W = 8;
   localparam int SW = 2;
   localparam int NV = 12;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [N-1:0] req_i = '0;
   logic glb_en_i = 1'b1;
   logic iack_i = 1'b0;
   logic wr_en_i = 1'b0;
   logic [SW-1:0] wr_sel_i = '0;
   logic [W-1:0] wr_data_i = '0;
   logic [SW-1:0] rd_sel_i = '0;
   logic irq_o;
   logic [W-1:0] vec_o, rd_data_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #5 clk = ~clk;

   irq_vector_arbiter #(.NUM_PORTS(N), .VEC_W(W)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_i(req_i), .glb_en_i(glb_en_i), .irq_o(irq_o),
      .iack_i(iack_i), .vec_o(vec_o), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
      .wr_data_i(wr_data_i), .rd_sel_i(rd_sel_i), .rd_data_o(rd_data_o));

   // {request pattern, expected vector}; vectors A0/A1/A2 for ports 0/1/2 (R4 walk).
   localparam logic [N+W-1:0] VECS [NV] = '{
      {3'b111, 8'hA0}, {3'b111, 8'hA1}, {3'b111, 8'hA2}, {3'b001, 8'hA0},
      {3'b001, 8'hA0}, {3'b101, 8'hA2}, {3'b011, 8'hA0}, {3'b000, 8'h00},
      {3'b110, 8'hA1}, {3'b100, 8'hA2}, {3'b011, 8'hA0}, {3'b010, 8'hA1}};

   task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [SW-1:0] s, input logic [W-1:0] d);
      @(negedge clk); wr_en_i = 1'b1; wr_sel_i = s; wr_data_i = d;
      @(negedge clk); wr_en_i = 1'b0;
   endtask

   task automatic ack(input logic [N-1:0] r);
      @(negedge clk); req_i = r; iack_i = 1'b1;
      @(negedge clk); iack_i = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R2: reset state
      chk("R2 vec_o after reset", vec_o, 8'h00);
      chk("R2 irq_o after reset", {7'd0, irq_o}, 8'h00);
      for (int k = 0; k < N; k++) begin
         rd_sel_i = SW'(k); #1;
         chk("R2 vector reg after reset", rd_data_o, 8'h00);
      end
      rst_n = 1'b1;
      // R1: program and read back vectors
      for (int k = 0; k < N; k++) wr(SW'(k), 8'hA0 + W'(k));
      for (int k = 0; k < N; k++) begin
         rd_sel_i = SW'(k); #1;
         chk("R1 readback", rd_data_o, 8'hA0 + W'(k));
      end
      // R2/R4/R5: table walk, first step shows port 0 wins after reset
      for (int i = 0; i < NV; i++) begin
         @(negedge clk); req_i = VECS[i][N+W-1:W]; iack_i = 1'b1; #1;
         chk("R6 irq_o follows request", {7'd0, irq_o}, {7'd0, |VECS[i][N+W-1:W]});
         @(negedge clk); iack_i = 1'b0;
         chk((VECS[i][N+W-1:W] == '0) ? "R5 idle acknowledge" : "R4 rotation winner",
             vec_o, VECS[i][W-1:0]);
      end
      // R3: vec_o holds without acknowledge
      @(negedge clk); req_i = 3'b111;
      repeat (3) @(negedge clk);
      chk("R3 vector held", vec_o, 8'hA1);
      // R6: global enable off
      glb_en_i = 1'b0; #1;
      chk("R6 gated off", {7'd0, irq_o}, 8'h00);
      glb_en_i = 1'b1; #1;
      chk("R6 enabled", {7'd0, irq_o}, 8'h01);
      // R7: write and acknowledge same port same cycle (last served = 1 -> port 0 next)
      @(negedge clk); req_i = 3'b001; iack_i = 1'b1;
      wr_en_i = 1'b1; wr_sel_i = 2'd0; wr_data_i = 8'h5C;
      @(negedge clk); iack_i = 1'b0; wr_en_i = 1'b0;
      chk("R7 old vector returned", vec_o, 8'hA0);
      rd_sel_i = 2'd0; #1;
      chk("R7 write landed", rd_data_o, 8'h5C);
      // R8: out-of-range write ignored
      wr(2'd3, 8'hFF);
      for (int k = 0; k < N; k++) begin
         rd_sel_i = SW'(k); #1;
         chk("R8 untouched", rd_data_o, (k == 0) ? 8'h5C : 8'hA0 + W'(k));
      end
      // R5: empty acknowledge keeps pointer at port 0 -> next all-request gives port 1
      ack(3'b000);
      chk("R5 zero vector", vec_o, 8'h00);
      ack(3'b111);
      chk("R5 pointer kept", vec_o, 8'hA1);
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end
endmodule